// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block is the command-side front end of a model or checker for a four-bank, 32-bit double-data-rate SDRAM. On every rising clock edge it samples the command pins: chip select, row strobe, column strobe, write enable, two bank-select bits and twelve address bits. From these it decodes bank activate, precharge (one bank or all of them), read, write and mode register load. It tracks whether each bank is idle or active, and it holds the last row address, column address and mode opcode it accepted.

Decoded commands appear as one-cycle pulses on the cycle after the edge that sampled them. A command that breaks bank-state rules raises an illegal-command pulse instead of its own pulse. When clock enable is sampled low, every register holds its value. If clock enable is sampled low while all banks are idle, a power-down indication is raised. The data path, strobe timing and refresh counting are out of scope.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When clock enable is high and chip select is high, no command pulse or illegal pulse is raised and bank state is unchanged. With chip select low, the unused encodings also have no effect. These are refresh (row, column and write-enable pins L,L,H), burst stop (H,H,L) and no-op (H,H,H).
- R2: An activate is chip select L, row L, column H, write enable H. Sent to an idle bank, it makes bank `ba` active (bit `ba` of `bank_active`), loads `addr` into `row_addr`, and pulses `cmd_act` for one cycle after the sampling edge.
- R3: A precharge is chip select L, row L, column H, write enable L. With `addr[8]`=0 it idles bank `ba`. With `addr[8]`=1 it idles all banks. In both cases it pulses `cmd_pre`.
- R4: A read is chip select L, row H, column L, write enable H, and a write is the same with write enable L. Sent to an active bank, either one pulses `cmd_rd` or `cmd_wr` and loads `col_addr` = {`addr[9]`, `addr[7:0]`}.
- R5: A read or write to an active bank with `addr[8]`=1 sets `auto_pre` and returns that bank to idle on the same edge. With `addr[8]`=0 it clears `auto_pre` and the bank stays active.
- R6: A mode register load is all four command pins low. It pulses `cmd_mrs` and loads `mrs_sel` = `ba` (0 selects the mode register, 1 the extended mode register) and `mrs_op` = `addr`.
- R7: An activate to an active bank, or a read or write to an idle bank, pulses `illegal` instead of the command pulse. It leaves bank state, row and column addresses unchanged.
- R8: At an edge where `cke` is sampled low, every register except `pdn` holds its value, and this includes the command pulses. The command pins are ignored.
- R9: `pdn` is 1 after an edge where `cke` was low and all banks were idle. Otherwise it is 0.
- R10: Reset (`rst_n` low, asynchronous) idles all banks and clears the row address, column address, mode outputs, command pulses, `illegal` and `pdn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes state |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select / mode register select |
| addr | input | 12 | Row, column or opcode bits |
| bank_active | output | 4 | One bit per bank, 1 = active |
| row_addr | output | 12 | Last accepted activate row |
| col_addr | output | 9 | Last accepted column |
| auto_pre | output | 1 | Last access requested auto-precharge |
| mrs_sel | output | 2 | Register chosen by last mode load |
| mrs_op | output | 12 | Opcode of last mode load |
| cmd_act | output | 1 | Activate accepted pulse |
| cmd_pre | output | 1 | Precharge accepted pulse |
| cmd_rd | output | 1 | Read accepted pulse |
| cmd_wr | output | 1 | Write accepted pulse |
| cmd_mrs | output | 1 | Mode load accepted pulse |
| illegal | output | 1 | Rule-breaking command pulse |
| pdn | output | 1 | Power-down entry indication |

## Verification
The bench drives the dual use of address bit 8. A design that mixes the two uses would idle only one bank on a precharge-all, or leave a bank open after an auto-precharge write. It sends an activate to a bank that is already open and a read to a closed bank. A design that lets these through would overwrite the row or report a bank as open when it is not. It holds clock enable low in two cases: all banks idle, and a bank open with an activate on the pins. A wrong design would then change state during the freeze or raise the power-down flag while a bank is still open. The column check uses an address whose bit 9 is set and bit 8 is clear, which exposes a column formed from the wrong bits.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int ADDR_W = 12,
  parameter int BANKS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [BANKS-1:0]  bank_active,
  output logic [ADDR_W-1:0] row_addr,
  output logic [8:0]        col_addr,
  output logic              auto_pre,
  output logic [1:0]        mrs_sel,
  output logic [ADDR_W-1:0] mrs_op,
  output logic              cmd_act,
  output logic              cmd_pre,
  output logic              cmd_rd,
  output logic              cmd_wr,
  output logic              cmd_mrs,
  output logic              illegal,
  output logic              pdn
);
  localparam int AP_BIT = 8;

  logic sel, is_act, is_pre, is_rd, is_wr, is_mrs, tgt_on;

  assign sel    = ~cs_n;
  assign is_act = sel & ~ras_n &  cas_n &  we_n;
  assign is_pre = sel & ~ras_n &  cas_n & ~we_n;
  assign is_rd  = sel &  ras_n & ~cas_n &  we_n;
  assign is_wr  = sel &  ras_n & ~cas_n & ~we_n;
  assign is_mrs = sel & ~ras_n & ~cas_n & ~we_n;
  assign tgt_on = bank_active[ba];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_active <= '0;
      row_addr    <= '0;
      col_addr    <= '0;
      auto_pre    <= 1'b0;
      mrs_sel     <= '0;
      mrs_op      <= '0;
      cmd_act     <= 1'b0;
      cmd_pre     <= 1'b0;
      cmd_rd      <= 1'b0;
      cmd_wr      <= 1'b0;
      cmd_mrs     <= 1'b0;
      illegal     <= 1'b0;
      pdn         <= 1'b0;
    end else begin
      pdn <= ~cke & ~|bank_active;
      if (cke) begin
        cmd_act <= 1'b0;
        cmd_pre <= 1'b0;
        cmd_rd  <= 1'b0;
        cmd_wr  <= 1'b0;
        cmd_mrs <= 1'b0;
        illegal <= 1'b0;
        if (is_act) begin
          if (tgt_on) illegal <= 1'b1;
          else begin
            bank_active[ba] <= 1'b1;
            row_addr        <= addr;
            cmd_act         <= 1'b1;
          end
        end else if (is_pre) begin
          cmd_pre <= 1'b1;
          if (addr[AP_BIT]) bank_active <= '0;
          else bank_active[ba] <= 1'b0;
        end else if (is_rd || is_wr) begin
          if (!tgt_on) illegal <= 1'b1;
          else begin
            cmd_rd   <= is_rd;
            cmd_wr   <= is_wr;
            col_addr <= {addr[9], addr[7:0]};
            auto_pre <= addr[AP_BIT];
            if (addr[AP_BIT]) bank_active[ba] <= 1'b0;
          end
        end else if (is_mrs) begin
          cmd_mrs <= 1'b1;
          mrs_sel <= ba;
          mrs_op  <= addr;
        end
      end
    end
  end

  a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cs_n) |=> !(cmd_act | cmd_pre | cmd_rd | cmd_wr | cmd_mrs | illegal) && $stable(bank_active));

  a_r2_activate: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && is_act && !tgt_on) |=> cmd_act && row_addr == $past(addr) && bank_active[$past(ba)]);

  a_r3_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && is_pre && addr[AP_BIT]) |=> bank_active == '0 && cmd_pre);

  a_r5_autopre: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && (is_rd || is_wr) && tgt_on && addr[AP_BIT]) |=> auto_pre && !bank_active[$past(ba)]);

  a_r7_busy_act: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && is_act && tgt_on) |=> illegal && !cmd_act && $stable(row_addr) && $stable(bank_active));

  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_act, cmd_pre, cmd_rd, cmd_wr, cmd_mrs, illegal}));

  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(bank_active) && $stable(row_addr) && $stable(col_addr) && $stable(cmd_act));

  a_r9_pdn: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && bank_active == '0) |=> pdn);
endmodule

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] ba = 0;
  logic [11:0] addr = 0;
  logic [3:0] bank_active;
  logic [11:0] row_addr, mrs_op;
  logic [8:0] col_addr;
  logic [1:0] mrs_sel;
  logic auto_pre, cmd_act, cmd_pre, cmd_rd, cmd_wr, cmd_mrs, illegal, pdn;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .bank_active(bank_active), .row_addr(row_addr),
    .col_addr(col_addr), .auto_pre(auto_pre), .mrs_sel(mrs_sel), .mrs_op(mrs_op),
    .cmd_act(cmd_act), .cmd_pre(cmd_pre), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_mrs(cmd_mrs), .illegal(illegal), .pdn(pdn));

  // {cke, cs,ras,cas,we, ba, addr, exp banks, exp {act,pre,rd,wr,mrs,ill}, exp pdn}
  localparam logic [29:0] VEC [16] = '{
    {1'b1, 4'b1111, 2'd0, 12'h000, 4'b0000, 6'b000000, 1'b0}, // R1 idle
    {1'b1, 4'b0011, 2'd1, 12'h123, 4'b0010, 6'b100000, 1'b0}, // R2
    {1'b1, 4'b0011, 2'd1, 12'h456, 4'b0010, 6'b000001, 1'b0}, // R7 act busy
    {1'b1, 4'b0101, 2'd0, 12'h000, 4'b0010, 6'b000001, 1'b0}, // R7 read idle
    {1'b1, 4'b0011, 2'd3, 12'hABC, 4'b1010, 6'b100000, 1'b0}, // R2
    {1'b1, 4'b0101, 2'd1, 12'h0FF, 4'b1010, 6'b001000, 1'b0}, // R4
    {1'b1, 4'b0100, 2'd3, 12'h100, 4'b0010, 6'b000100, 1'b0}, // R5
    {1'b1, 4'b1011, 2'd0, 12'h000, 4'b0010, 6'b000000, 1'b0}, // R1 deselect
    {1'b1, 4'b0001, 2'd0, 12'h000, 4'b0010, 6'b000000, 1'b0}, // R1 refresh code
    {1'b1, 4'b0010, 2'd1, 12'h000, 4'b0000, 6'b010000, 1'b0}, // R3 single
    {1'b1, 4'b0011, 2'd0, 12'h011, 4'b0001, 6'b100000, 1'b0},
    {1'b1, 4'b0011, 2'd2, 12'h022, 4'b0101, 6'b100000, 1'b0},
    {1'b1, 4'b0010, 2'd0, 12'h100, 4'b0000, 6'b010000, 1'b0}, // R3 all
    {1'b1, 4'b0000, 2'd1, 12'h5A5, 4'b0000, 6'b000010, 1'b0}, // R6
    {1'b0, 4'b0011, 2'd0, 12'h000, 4'b0000, 6'b000010, 1'b1}, // R8 R9
    {1'b1, 4'b0111, 2'd0, 12'h000, 4'b0000, 6'b000000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic [3:0] c, input logic [1:0] b, input logic [11:0] a);
    cke = k; {cs_n, ras_n, cas_n, we_n} = c; ba = b; addr = a;
    @(negedge clk);
  endtask

  function automatic logic [5:0] pulses();
    return {cmd_act, cmd_pre, cmd_rd, cmd_wr, cmd_mrs, illegal};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R10 reset banks", 32'(bank_active), 0);
    chk("R10 reset pulses", 32'({pulses(), pdn}), 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      drive(VEC[i][29], VEC[i][28:25], VEC[i][24:23], VEC[i][22:11]);
      chk($sformatf("R1-table row %0d banks", i), 32'(bank_active), 32'(VEC[i][10:7]));
      chk($sformatf("R7 table row %0d pulses", i), 32'(pulses()), 32'(VEC[i][6:1]));
      chk($sformatf("R9 table row %0d pdn", i), 32'(pdn), 32'(VEC[i][0]));
    end
    chk("R6 mrs_sel", 32'(mrs_sel), 1);
    chk("R6 mrs_op", 32'(mrs_op), 32'h5A5);
    drive(1, 4'b0011, 2, 12'h7E1);
    chk("R2 row_addr", 32'(row_addr), 32'h7E1);
    drive(1, 4'b0101, 2, 12'h2C5);
    chk("R4 col_addr", 32'(col_addr), 32'h1C5);
    chk("R5 no autopre", 32'({auto_pre, bank_active}), 32'h04);
    drive(1, 4'b0100, 2, 12'h1FF);
    chk("R5 col_addr", 32'(col_addr), 32'h0FF);
    chk("R5 autopre idle", 32'({auto_pre, bank_active}), 32'h10);
    drive(1, 4'b0011, 0, 12'h3C3);
    for (int k = 0; k < 3; k++) begin
      drive(0, 4'b0011, 1, 12'h999);
      chk("R8 frozen banks", 32'(bank_active), 32'h1);
      chk("R8 frozen row/pulse", 32'({row_addr, cmd_act}), 32'({12'h3C3, 1'b1}));
      chk("R9 no pdn with open bank", 32'(pdn), 0);
    end
    drive(1, 4'b0010, 0, 12'h100);
    chk("R3 pre all", 32'(bank_active), 0);
    drive(1, 4'b0000, 0, 12'h033);
    chk("R6 mode reg", 32'({mrs_sel, mrs_op}), 32'({2'd0, 12'h033}));
    drive(1, 4'b0011, 3, 12'h444);
    rst_n = 0;
    #1;
    chk("R10 async reset", 32'({bank_active, row_addr, col_addr, auto_pre, pulses(), pdn}), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule